// File: doc/BRIEF.md
# Serial shift-and-store output register

This block turns a serial bit stream into a parallel word. It has three parts: a chain of shift stages, a storage register that holds the parallel word, and a parallel output bank with a drive-enable for each bit. Everything runs on one fast system clock. The shift clock and the strobe are treated as slow, asynchronous levels. The block synchronises them and detects their edges internally. Each detected rising edge of the shift clock produces exactly one shift event.

While the strobe is high, the storage register is transparent to the shift stages. While the strobe is low, it holds its value. The output-enable input only sets the drive-enable flags of the parallel bank. It never stops shifting or storing.

Two cascade outputs copy the last shift stage. The first one changes together with the shift. The second one is re-timed to the falling edge of the shift clock. That gives the next device in a slow chain half a shift period of hold margin.

Top module: `ser_store_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the shift stages, the storage register, `par_drv` and both cascade outputs become all zero on that edge.
- R2: On every rising edge of `sclk_in`, stage 0 takes `ser_in` and stage n takes stage n-1 for n = 1 to WIDTH-1. Bit n of `par_out` shows stage n.
- R3: While the synchronised strobe is high, `par_out` equals the shift stages. This includes the cycle of a shift event, when `par_out` shows the value after the shift.
- R4: While the synchronised strobe is low, `par_out` holds its value, even while shifting continues.
- R5: One clock after `oe_in` is high, `par_drv` is all ones. One clock after `oe_in` is low, `par_drv` is all zeros.
- R6: With `oe_in` low, shifting and storage loading still take place. Raising `oe_in` afterwards shows the word that was loaded meanwhile.
- R7: `casc_rise` equals the last stage (bit WIDTH-1) after each shift event. It changes at no other time.
- R8: `casc_fall` takes the last stage on each falling edge of `sclk_in` and keeps its value across rising edges. It therefore lags `casc_rise` by half a shift-clock period.
- R9: With the default two-flop synchroniser, a rising edge of `sclk_in` that is set up before clock edge k appears on `par_out` and `casc_rise` at clock edge k+2, not earlier. `ser_in` is delayed by the same amount, so it is sampled at the same moment as the shift clock.
- R10: In a chain of two instances, with `casc_rise` of the first instance feeding `ser_in` of the second, 16 shift edges followed by a strobe pulse leave the first 8 bits shifted in on the second instance's `par_out` and the last 8 bits on the first instance's `par_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data input |
| sclk_in | input | 1 | Shift clock, sampled as a level |
| strobe_in | input | 1 | Storage transparency control, sampled as a level |
| oe_in | input | 1 | Parallel output enable |
| par_out | output | WIDTH | Storage register contents |
| par_drv | output | WIDTH | Per-bit drive enable for `par_out` (0 stands for high impedance) |
| casc_rise | output | 1 | Last stage, updated on the shift event |
| casc_fall | output | 1 | Last stage, re-timed to the falling shift-clock edge |

## Verification
A shift event and a transparent storage load can occur in the same system-clock cycle. To provoke this, the strobe is held high while rising shift-clock edges arrive. The parallel word is then read exactly two and three clock edges after the rising edge is applied. It must show the old contents first and the post-shift contents second, with no cycle in which it shows a stale word. Output-enable changes are also made while shifts are happening, and the bench checks that the loaded word is unaffected.

// File: rtl/ser_store_pkg.sv
`timescale 1ns/1ps
package ser_store_pkg;
  // Edge events of a synchronised slow clock
  typedef struct packed {
    logic rise;
    logic fall;
  } slow_evt_t;

  localparam int unsigned DEF_SYNC_DEPTH = 2;
endpackage

// File: rtl/level_sync.sv
`timescale 1ns/1ps
// Plain multi-flop synchroniser / delay line for a level signal
module level_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [DEPTH-1:0] pipe;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[DEPTH-2:0], d_in};
      end
    end
  endgenerate

  assign q_out = pipe[DEPTH-1];
endmodule

// File: rtl/edge_sync.sv
`timescale 1ns/1ps
// Synchroniser with one extra history flop to detect both edges
module edge_sync
  import ser_store_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_SYNC_DEPTH
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      a_in,
  output slow_evt_t evt
);
  logic [DEPTH:0] pipe;
  logic           cur;
  logic           prev;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[DEPTH-1:0], a_in};
  end

  assign cur      = pipe[DEPTH-1];
  assign prev     = pipe[DEPTH];
  assign evt.rise = cur & ~prev;
  assign evt.fall = ~cur & prev;
endmodule

// File: rtl/shift_chain.sv
`timescale 1ns/1ps
// Serial-in shift stages; q_next exposes the post-shift value
module shift_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_next
);
  generate
    for (genvar n = 0; n < WIDTH; n++) begin : g_stage
      if (n == 0) begin : g_head
        assign q_next[n] = shift_en ? din : q[n];
      end else begin : g_body
        assign q_next[n] = shift_en ? q[n-1] : q[n];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/store_bank.sv
`timescale 1ns/1ps
// Storage register (transparent while strobe high) and drive enables
module store_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             str_lvl,
  input  logic [WIDTH-1:0] load_val,
  input  logic             oe,
  output logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] drv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      drv  <= '0;
    end else begin
      if (str_lvl) word <= load_val;
      drv <= {WIDTH{oe}};
    end
  end
endmodule

// File: rtl/ser_store_reg.sv
`timescale 1ns/1ps
module ser_store_reg
  import ser_store_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             sclk_in,
  input  logic             strobe_in,
  input  logic             oe_in,
  output logic [WIDTH-1:0] par_out,
  output logic [WIDTH-1:0] par_drv,
  output logic             casc_rise,
  output logic             casc_fall
);
  localparam int unsigned LAST = WIDTH - 1;

  slow_evt_t        sclk_evt;
  logic             shift_evt;
  logic             str_lvl;
  logic             din_al;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] shift_nx;

  edge_sync #(.DEPTH(SYNC_DEPTH)) u_sclk_sync (
    .clk (clk), .rst (rst), .a_in (sclk_in), .evt (sclk_evt)
  );

  // Strobe uses the same depth so its level lines up with shift events
  level_sync #(.DEPTH(SYNC_DEPTH)) u_str_sync (
    .clk (clk), .rst (rst), .d_in (strobe_in), .q_out (str_lvl)
  );

  // Data delayed to match the shift-clock synchroniser
  level_sync #(.DEPTH(SYNC_DEPTH)) u_din_align (
    .clk (clk), .rst (rst), .d_in (ser_in), .q_out (din_al)
  );

  assign shift_evt = sclk_evt.rise;

  shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_evt),
    .din      (din_al),
    .q        (shift_q),
    .q_next   (shift_nx)
  );

  store_bank #(.WIDTH(WIDTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .str_lvl  (str_lvl),
    .load_val (shift_nx),
    .oe       (oe_in),
    .word     (par_out),
    .drv      (par_drv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      casc_rise <= 1'b0;
      casc_fall <= 1'b0;
    end else begin
      if (shift_evt)     casc_rise <= shift_nx[LAST];
      if (sclk_evt.fall) casc_fall <= shift_q[LAST];
    end
  end
endmodule

// File: rtl/ser_store_chk.sv
`timescale 1ns/1ps
module ser_store_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             oe_in,
  input logic             str_lvl,
  input logic             shift_evt,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] par_out,
  input logic [WIDTH-1:0] par_drv,
  input logic             casc_rise,
  input logic             casc_fall
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (par_out == '0 && par_drv == '0 && !casc_rise && !casc_fall));

  assert_transparent_R3: assert property (@(posedge clk) disable iff (rst)
    str_lvl |=> (par_out == shift_q));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !str_lvl |=> $stable(par_out));

  assert_drv_on_R5: assert property (@(posedge clk) disable iff (rst)
    oe_in |=> (par_drv == '1));

  assert_drv_off_R5: assert property (@(posedge clk) disable iff (rst)
    !oe_in |=> (par_drv == '0));

  assert_rise_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(casc_rise));

  assert_fall_copy_R8: assert property (@(posedge clk) disable iff (rst)
    (casc_fall != $past(casc_fall)) |-> (casc_fall == casc_rise));
endmodule

bind ser_store_reg ser_store_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .oe_in     (oe_in),
  .str_lvl   (str_lvl),
  .shift_evt (shift_evt),
  .shift_q   (shift_q),
  .par_out   (par_out),
  .par_drv   (par_drv),
  .casc_rise (casc_rise),
  .casc_fall (casc_fall)
);

// File: tb/test_ser_store_reg.sv
`timescale 1ns/1ps
module test_ser_store_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic sclk = 1'b0;
  logic strobe = 1'b0;
  logic oe = 1'b0;

  logic [W-1:0] pa_out, pa_drv, pb_out, pb_drv;
  logic ca_rise, ca_fall, cb_rise, cb_fall;

  logic [2*W-1:0] refv = '0;
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ser_store_reg #(.WIDTH(W)) i_ser_store_reg (
    .clk(clk), .rst(rst), .ser_in(din), .sclk_in(sclk), .strobe_in(strobe),
    .oe_in(oe), .par_out(pa_out), .par_drv(pa_drv),
    .casc_rise(ca_rise), .casc_fall(ca_fall)
  );

  ser_store_reg #(.WIDTH(W)) i_ser_store_reg_nxt (
    .clk(clk), .rst(rst), .ser_in(ca_rise), .sclk_in(sclk), .strobe_in(strobe),
    .oe_in(oe), .par_out(pb_out), .par_drv(pb_drv),
    .casc_rise(cb_rise), .casc_fall(cb_fall)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic b);
    din = b; sclk = 1'b1; tick(6);
    refv = {refv[2*W-2:0], b};
    sclk = 1'b0; tick(6);
  endtask

  task automatic do_reset();
    oe = 1'b0; strobe = 1'b0; sclk = 1'b0; din = 1'b0;
    rst = 1'b1; tick(3); rst = 1'b0; tick(1);
    refv = '0;
  endtask

  // R1: reset clears everything, also after activity
  task automatic t_reset();
    do_reset();
    chk("R1 par_out", pa_out, 0);
    chk("R1 par_drv", pa_drv, 0);
    chk("R1 casc", {ca_rise, ca_fall}, 0);
    strobe = 1'b1; oe = 1'b1; tick(4);
    for (int i = 0; i < 5; i++) push(1'b1);
    do_reset();
    chk("R1 par_out after run", pa_out, 0);
    chk("R1 casc after run", {ca_rise, ca_fall}, 0);
  endtask

  // R2/R3: transparent strobe, word follows each shift
  task automatic t_shift();
    logic [W-1:0] pat = 8'hA5;
    do_reset();
    strobe = 1'b1; oe = 1'b1; tick(4);
    for (int i = W-1; i >= 0; i--) begin
      push(pat[i]);
      chk("R2 shift word", pa_out, refv[W-1:0]);
    end
    chk("R3 full word", pa_out, 8'hA5);
  endtask

  // R4: strobe low freezes word while shifting continues
  task automatic t_hold();
    logic [W-1:0] held;
    strobe = 1'b0; tick(4);
    held = pa_out;
    push(1'b0); push(1'b1); push(1'b1);
    chk("R4 held word", pa_out, held);
    strobe = 1'b1; tick(4);
    chk("R4 word after release", pa_out, refv[W-1:0]);
  endtask

  // R5/R6: output enable independent of shifting and storing
  task automatic t_oe();
    oe = 1'b0; tick(2);
    chk("R5 drv off", pa_drv, 0);
    push(1'b1); push(1'b0); push(1'b0); push(1'b1);
    strobe = 1'b0; tick(4);
    oe = 1'b1; tick(2);
    chk("R5 drv on", pa_drv, 8'hFF);
    chk("R6 word loaded while disabled", pa_out, refv[W-1:0]);
  endtask

  // R7/R8: cascade outputs and half-period lag
  task automatic t_cascade();
    logic prev7;
    for (int i = 0; i < 8; i++) begin
      prev7 = refv[W-1];
      din = i[0]; sclk = 1'b1; tick(6);
      refv = {refv[2*W-2:0], i[0]};
      chk("R7 casc_rise after rise", ca_rise, refv[W-1]);
      chk("R8 casc_fall held at rise", ca_fall, prev7);
      sclk = 1'b0; tick(6);
      chk("R8 casc_fall after fall", ca_fall, refv[W-1]);
    end
  endtask

  // R9: shift and transparent load in the same cycle, exact latency
  task automatic t_latency();
    logic b;
    strobe = 1'b1; tick(4);
    b = ~refv[0];
    din = b; sclk = 1'b1;
    tick(2);
    chk("R9 not yet at edge k+1", pa_out, refv[W-1:0]);
    tick(1);
    chk("R9 post-shift at edge k+2", pa_out, {refv[W-2:0], b});
    chk("R9 casc_rise at edge k+2", ca_rise, refv[W-2]);
    tick(3);
    refv = {refv[2*W-2:0], b};
    sclk = 1'b0; tick(6);
  endtask

  // R10: two-instance chain, 16 shifts then strobe pulse
  task automatic t_chain();
    logic [2*W-1:0] pat = 16'hC3A9;
    do_reset();
    oe = 1'b1;
    for (int i = 2*W-1; i >= 0; i--) push(pat[i]);
    strobe = 1'b1; tick(4); strobe = 1'b0; tick(4);
    chk("R10 first instance", pa_out, pat[W-1:0]);
    chk("R10 second instance", pb_out, pat[2*W-1:W]);
    chk("R10 reference model", {pb_out, pa_out}, refv);
  endtask

  initial begin
    t_reset();
    t_shift();
    t_hold();
    t_oe();
    t_cascade();
    t_latency();
    t_chain();
    summary();
  end
endmodule